// File: doc/BRIEF.md
# Self-Timed Program Sequencer with Ready/Busy Status

This block sits behind the serial command decoder of a small serial EEPROM model. When a write-class frame (single word write, all-word write, single word erase or all-word erase) has been fully received, the command decoder hands the sequencer one request strobe, along with the request kind, word address and data word. The strobe comes in the cycle in which chip select falls. The sequencer then counts a fixed number of system clock cycles to stand in for the self-timed programming interval. When the count ends, it emits a single-cycle update strobe that carries everything the array needs to commit the change.

The serial data output has its own status path. Whenever chip select is high and a programming interval is running or has just ended, the output is enabled. It shows 0 while the interval is still running and 1 once it is done. This level follows chip select directly, so polling needs no serial clock. The ready level stays available until the decoder reports a received start bit. After that the output goes back to high impedance, and the same start bit can begin a new command. A busy flag tells the decoder to hold off new instructions. Requests that arrive while busy are discarded.

Top module: `prog_sequencer`

## Requirements
- R1: After reset `busy` and `updValid` are 0, and `statusOe` is 0 even with `csIn` high.
- R2: A `progReq` pulse taken while idle raises `busy` at the next clock edge, and `busy` then stays high for exactly CYCLE_LEN clock cycles.
- R3: In the first cycle after `busy` falls, `updValid` is 1 for exactly one cycle. `updKind` and `updAddr` then show the accepted request. Kind codes are 0 = word write, 1 = all-word write, 2 = word erase, 3 = all-word erase.
- R4: For the erase kinds (code bit 1 set), `updData` is all ones whatever data came with the request. For the write kinds it is the request data.
- R5: While `busy` is 1 and `csIn` is 1, `statusOe` is 1 and `statusDo` is 0.
- R6: Once programming has ended, raising `csIn` gives `statusOe` = 1 and `statusDo` = 1 with no clock edge needed.
- R7: Whenever `csIn` is 0, `statusOe` is 0, whether busy or ready.
- R8: The ready indication lasts through any number of `csIn` toggles. A `startStrobe` taken while idle clears it, so `statusOe` is 0 from the next cycle on.
- R9: Toggling `csIn` during the busy interval changes neither its length nor the update that follows.
- R10: A `progReq` or `startStrobe` that arrives while busy is dropped: the interval length and the captured kind, address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Chip select level, synchronous to clk |
| startStrobe | input | 1 | One-cycle pulse when the decoder has taken a start bit |
| progReq | input | 1 | One-cycle program request at chip select fall |
| reqKind | input | 2 | Request kind code (see R3) |
| reqAddr | input | ADDR_W | Word address of the request |
| reqData | input | DATA_W | Data word of the request |
| busy | output | 1 | Programming interval running |
| statusOe | output | 1 | Output enable for the serial data pin |
| statusDo | output | 1 | Status level: 0 busy, 1 ready |
| updValid | output | 1 | One-cycle array update strobe |
| updKind | output | 2 | Kind of the update |
| updAddr | output | ADDR_W | Address of the update |
| updData | output | DATA_W | Data to commit (all ones for erase) |

## Verification
The bench builds the sequencer with a 7-bit address, a 16-bit word and CYCLE_LEN of 12. This keeps each programming interval short enough to count every busy cycle edge by edge. It also leaves room to inject dropped requests and start strobes part-way through an interval and still see the whole interval. With the short interval, every request kind, every chip-select pattern during busy (held high, held low, toggled each cycle) and the full ready-then-clear sequence all fit in a few hundred cycles.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  typedef enum logic [1:0] {
    KIND_WORD_WR  = 2'd0,
    KIND_ALL_WR   = 2'd1,
    KIND_WORD_ERS = 2'd2,
    KIND_ALL_ERS  = 2'd3
  } progKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // accept the pending request
    logic finish;  // last busy cycle, commit at this edge
  } seqStrobe_t;

endpackage

// File: rtl/prog_seq_ctrl.sv
module prog_seq_ctrl
  import prog_seq_pkg::*;
#(
  parameter int CYCLE_LEN = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csIn,
  input  logic       startStrobe,
  input  logic       progReq,
  output seqStrobe_t strobes,
  output logic       busy,
  output logic       statusOe,
  output logic       statusDo
);

  localparam int CNT_W = (CYCLE_LEN < 2) ? 1 : $clog2(CYCLE_LEN);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLE_LEN - 1);

  logic [CNT_W-1:0] cycleCnt;
  logic             busyQ;
  logic             readyHold;
  logic             lastCycle;

  assign lastCycle      = busyQ && (cycleCnt == '0);
  assign strobes.load   = progReq && !busyQ;
  assign strobes.finish = lastCycle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      cycleCnt <= '0;
    end else if (strobes.load) begin
      busyQ    <= 1'b1;
      cycleCnt <= LOAD_VAL;
    end else if (busyQ) begin
      if (lastCycle) begin
        busyQ <= 1'b0;
      end else begin
        cycleCnt <= cycleCnt - 1'b1;
      end
    end
  end

  // Ready indication survives CS toggles; only a start bit (or new load) ends it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyHold <= 1'b0;
    end else if (lastCycle) begin
      readyHold <= 1'b1;
    end else if (strobes.load || (startStrobe && !busyQ)) begin
      readyHold <= 1'b0;
    end
  end

  assign busy     = busyQ;
  assign statusOe = csIn && (busyQ || readyHold);
  assign statusDo = statusOe && !busyQ;

endmodule

// File: rtl/prog_seq_data.sv
module prog_seq_data
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobes,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              updValid,
  output logic [1:0]        updKind,
  output logic [ADDR_W-1:0] updAddr,
  output logic [DATA_W-1:0] updData
);

  progKind_t         kindQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              isErase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ <= KIND_WORD_WR;
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobes.load) begin
      kindQ <= progKind_t'(reqKind);
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updValid <= 1'b0;
    end else begin
      updValid <= strobes.finish;
    end
  end

  assign isErase = (kindQ == KIND_WORD_ERS) || (kindQ == KIND_ALL_ERS);
  assign updKind = kindQ;
  assign updAddr = addrQ;
  assign updData = isErase ? {DATA_W{1'b1}} : dataQ;

endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
  import prog_seq_pkg::*;
#(
  parameter int CYCLE_LEN = 20,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic              startStrobe,
  input  logic              progReq,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              statusOe,
  output logic              statusDo,
  output logic              updValid,
  output logic [1:0]        updKind,
  output logic [ADDR_W-1:0] updAddr,
  output logic [DATA_W-1:0] updData
);

  seqStrobe_t strobes;

  prog_seq_ctrl #(.CYCLE_LEN(CYCLE_LEN)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csIn       (csIn),
    .startStrobe(startStrobe),
    .progReq    (progReq),
    .strobes    (strobes),
    .busy       (busy),
    .statusOe   (statusOe),
    .statusDo   (statusDo)
  );

  prog_seq_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqKind (reqKind),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .updValid(updValid),
    .updKind (updKind),
    .updAddr (updAddr),
    .updData (updData)
  );

endmodule

// File: rtl/prog_sequencer_chk.sv
module prog_sequencer_chk #(
  parameter int CYCLE_LEN = 20,
  parameter int ADDR_W    = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              csIn,
  input logic              startStrobe,
  input logic              progReq,
  input logic              busy,
  input logic              statusOe,
  input logic              statusDo,
  input logic              updValid,
  input logic [1:0]        updKind,
  input logic [ADDR_W-1:0] updAddr
);

  int runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      runLen <= 0;
    else if (busy)  runLen <= runLen + 1;
    else            runLen <= 0;
  end

  // R2: busy interval lasts CYCLE_LEN cycles
  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == CYCLE_LEN));

  // R3: update strobe coincides with end of busy and lasts one cycle
  a_r3_update_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> updValid);

  a_r3_update_single: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> !updValid);

  // R5: busy level on the output while selected
  a_r5_busy_level: assert property (@(posedge clk) disable iff (!rstN)
    (busy && csIn) |-> (statusOe && !statusDo));

  // R7: deselected means output off
  a_r7_oe_off: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |-> !statusOe);

  // R8: start bit while idle clears the ready indication
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    (startStrobe && !busy && !progReq) |=> !statusOe);

  // R10: a request while busy leaves the pending update untouched
  a_r10_drop_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (progReq && busy) |=> ($stable(updAddr) && $stable(updKind)));

endmodule

bind prog_sequencer prog_sequencer_chk #(
  .CYCLE_LEN(CYCLE_LEN),
  .ADDR_W   (ADDR_W)
) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .csIn       (csIn),
  .startStrobe(startStrobe),
  .progReq    (progReq),
  .busy       (busy),
  .statusOe   (statusOe),
  .statusDo   (statusDo),
  .updValid   (updValid),
  .updKind    (updKind),
  .updAddr    (updAddr)
);

// File: tb/test_prog_sequencer.sv
module test_prog_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int CYC = 12;
  localparam int AW  = 7;
  localparam int DW  = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csIn = 1'b0;
  logic          startStrobe = 1'b0;
  logic          progReq = 1'b0;
  logic [1:0]    reqKind = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic          busy, statusOe, statusDo, updValid;
  logic [1:0]    updKind;
  logic [AW-1:0] updAddr;
  logic [DW-1:0] updData;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_sequencer #(.CYCLE_LEN(CYC), .ADDR_W(AW), .DATA_W(DW)) i_prog_sequencer (
    .clk(clk), .rstN(rstN), .csIn(csIn), .startStrobe(startStrobe),
    .progReq(progReq), .reqKind(reqKind), .reqAddr(reqAddr), .reqData(reqData),
    .busy(busy), .statusOe(statusOe), .statusDo(statusDo), .updValid(updValid),
    .updKind(updKind), .updAddr(updAddr), .updData(updData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one programming interval. csMode: 0 low, 1 high, 2 toggling.
  task automatic run_cycle(input logic [1:0] kind, input logic [AW-1:0] addr,
                           input logic [DW-1:0] data, input int csMode, input bit inject);
    int n;
    logic [DW-1:0] expData;
    expData = kind[1] ? {DW{1'b1}} : data;
    @(negedge clk);
    csIn = 1'b0; reqKind = kind; reqAddr = addr; reqData = data; progReq = 1'b1;
    @(negedge clk);
    progReq = 1'b0;
    n = 0;
    while (busy && n < CYC + 5) begin
      n++;
      if (csMode == 2) csIn = n[0];
      else csIn = (csMode == 1);
      if (inject && n == 3) begin
        progReq = 1'b1; startStrobe = 1'b1;
        reqKind = ~kind; reqAddr = ~addr; reqData = ~data;
      end else begin
        progReq = 1'b0; startStrobe = 1'b0;
      end
      #1;
      if (csIn) check(statusOe && !statusDo, "R5", {statusOe, statusDo}, 2'b10);
      else      check(!statusOe, "R7", statusOe, 0);
      @(negedge clk);
    end
    progReq = 1'b0; startStrobe = 1'b0;
    #1;
    check(n == CYC, inject ? "R10" : (csMode == 2 ? "R9" : "R2"), n, CYC);
    check(updValid == 1'b1, "R3", updValid, 1);
    check(updKind == kind, inject ? "R10" : "R3", updKind, kind);
    check(updAddr == addr, inject ? "R10" : "R3", updAddr, addr);
    check(updData == expData, kind[1] ? "R4" : "R3", updData, expData);
    @(negedge clk);
    #1;
    check(updValid == 1'b0, "R3", updValid, 0);
  endtask

  task automatic t_reset;
    rstN = 1'b0; csIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(!busy, "R1", busy, 0);
    check(!statusOe, "R1", statusOe, 0);
    check(!updValid, "R1", updValid, 0);
    csIn = 1'b0;
  endtask

  task automatic t_word_write_selected;
    run_cycle(2'd0, 7'h15, 16'hA5C3, 1, 1'b0);
  endtask

  task automatic t_ready_poll;
    run_cycle(2'd1, 7'h7F, 16'h1234, 0, 1'b0);
    csIn = 1'b1; #1;  // no clock edge between CS rise and sample
    check(statusOe && statusDo, "R6", {statusOe, statusDo}, 2'b11);
    @(negedge clk); csIn = 1'b0; #1;
    check(!statusOe, "R7", statusOe, 0);
    @(negedge clk); csIn = 1'b1; #1;
    check(statusOe && statusDo, "R8", {statusOe, statusDo}, 2'b11);
    @(negedge clk); startStrobe = 1'b1;
    @(negedge clk); startStrobe = 1'b0; #1;
    check(!statusOe, "R8", statusOe, 0);
    csIn = 1'b0;
  endtask

  task automatic t_erase_kinds;
    run_cycle(2'd2, 7'h2A, 16'h0F0F, 0, 1'b0);
    run_cycle(2'd3, 7'h01, 16'h0000, 1, 1'b0);
  endtask

  task automatic t_cs_toggle;
    run_cycle(2'd0, 7'h33, 16'hBEEF, 2, 1'b0);
  endtask

  task automatic t_drop_while_busy;
    run_cycle(2'd0, 7'h4C, 16'h5AA5, 1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_word_write_selected();
    t_ready_poll();
    t_erase_kinds();
    t_cs_toggle();
    t_drop_while_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule